// File: doc/BRIEF.md
# Disturbance-aware read-restore controller

This controller sits between an operand-collection stage and a banked register array whose cells may lose their contents when they are read. Each incoming read names a register and carries two hints: a compiler flag marking the read as the last use of the value, and a flag saying the value comes from a small SRAM read buffer rather than the array. The controller sends array reads to the right bank and decides, for each one, whether the word must be written back afterwards.

A read that is not the last use is followed by a restore write of the word that was just fetched. That word is held in a per-bank holding register. The restore runs in one of two modes, chosen per read from that bank's queue status. When other requests are waiting for the bank, a fast one-cycle direct rewrite is used. When the bank is idle, a slower three-cycle low-energy rewrite is used. A last-use read releases its bank with no write. A buffer-served read never touches the array. Three event counters make the policy visible at the ports.

Top module: `restore_ctl`

## Requirements
- R1: A register ID selects bank `id[1:0]` and row `id[7:2]`. The array read and any restore write for it use that bank and row.
- R2: A read with neither hint set produces exactly one restore write, on the bank's `rst_wr_en` bit, in the cycle after its read cycle. The data written is the word the array returned in the read cycle.
- R3: A read with the last-use hint set produces no restore write. It occupies its bank for its read cycle only and adds one to `cnt_skip`. When a value is read several times and only the final read carries the hint, every earlier read is still restored.
- R4: If the bank's `bank_pending` bit is high in the read cycle, the restore is direct: `rst_wr_mode` is 0 and the bank is busy for 2 cycles in total. `cnt_direct` rises by one.
- R5: If the bank's `bank_pending` bit is low in the read cycle, the restore is selective: `rst_wr_mode` is 1 and the bank is busy for 4 cycles in total. `cnt_sel` rises by one.
- R6: A read with the buffer hint set is always accepted (`req_ready` = 1). It issues no array read, leaves every `bank_busy` bit low, writes nothing and changes no counter.
- R7: While a bank is busy, array reads to that bank are refused (`req_ready` = 0). Reads to other banks are still accepted in the same cycle.
- R8: A restore writes the word held for its own read. Data returned for a later read of another bank does not alter it.
- R9: After reset all counters are 0, all banks are idle and no write is issued. Each counter rises by exactly one per counted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_reg_id | input | 8 | Register ID of the read |
| req_dead | input | 1 | Last-use hint from the compiler |
| req_buf_hit | input | 1 | Read is served by the SRAM read buffer |
| req_ready | output | 1 | Request is accepted this cycle |
| bank_pending | input | 4 | Per-bank flag: requests waiting in that bank's queue |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rd_bank | output | 2 | Bank of the array read |
| arr_rd_row | output | 6 | Row of the array read |
| arr_rd_data | input | 32 | Array read data, valid in the cycle after the strobe |
| rst_wr_en | output | 4 | Per-bank restore write strobe |
| rst_wr_mode | output | 4 | Per-bank restore mode (0 direct, 1 selective) |
| rst_wr_row | output | 24 | Per-bank restore row, 6 bits per bank |
| rst_wr_data | output | 128 | Per-bank restore data, 32 bits per bank |
| bank_busy | output | 4 | Per-bank occupancy flag |
| cnt_skip | output | 16 | Count of skipped restores |
| cnt_direct | output | 16 | Count of direct restores |
| cnt_sel | output | 16 | Count of selective restores |

## Verification
The two functions that meet in one cycle are one bank's restore write and a new array read in a different bank. Both can also meet a refused read to the bank that is still restoring. The bench provokes this by sending a read to bank 0. In the next cycle it first offers a read to bank 0, which must be refused, and then a read to bank 1, which must be accepted. The array model returns a different pattern for every bank and row and junk in idle cycles. A scoreboard then judges that the bank 0 write carries its own word while bank 1's fetch overlaps it.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

   typedef enum logic [1:0] {
      BK_IDLE     = 2'd0,
      BK_FETCH    = 2'd1,
      BK_RST_FAST = 2'd2,
      BK_RST_SLOW = 2'd3
   } bank_state_e;

   localparam logic MODE_DIRECT = 1'b0;
   localparam logic MODE_SEL    = 1'b1;

endpackage

// File: rtl/rrc_bank.sv
module rrc_bank
   import rrc_pkg::*;
#(
   parameter int ROW_W      = 6,
   parameter int DATA_W     = 32,
   parameter int DIRECT_CYC = 1,
   parameter int SEL_CYC    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_dead,
   input  logic [ROW_W-1:0]  start_row,
   input  logic              pending,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic              wr_mode,
   output logic [ROW_W-1:0]  wr_row,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              ev_skip,
   output logic              ev_direct,
   output logic              ev_sel
);

   localparam int TMR_MAX = (SEL_CYC > DIRECT_CYC) ? SEL_CYC : DIRECT_CYC;
   localparam int TMR_W   = (TMR_MAX > 2) ? $clog2(TMR_MAX) : 1;

   bank_state_e       state_q;
   logic              dead_q;
   logic              first_q;
   logic [ROW_W-1:0]  row_q;
   logic [DATA_W-1:0] hold_q;
   logic [TMR_W-1:0]  tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BK_IDLE;
         dead_q  <= 1'b0;
         first_q <= 1'b0;
         row_q   <= '0;
         hold_q  <= '0;
         tmr_q   <= '0;
      end else begin
         case (state_q)
            BK_IDLE: begin
               if (start) begin
                  state_q <= BK_FETCH;
                  dead_q  <= start_dead;
                  row_q   <= start_row;
               end
            end
            BK_FETCH: begin
               if (dead_q) begin
                  state_q <= BK_IDLE;
               end else begin
                  hold_q  <= rd_data;
                  first_q <= 1'b1;
                  if (pending) begin
                     state_q <= BK_RST_FAST;
                     tmr_q   <= TMR_W'(DIRECT_CYC - 1);
                  end else begin
                     state_q <= BK_RST_SLOW;
                     tmr_q   <= TMR_W'(SEL_CYC - 1);
                  end
               end
            end
            default: begin
               first_q <= 1'b0;
               if (tmr_q == '0) state_q <= BK_IDLE;
               else             tmr_q   <= tmr_q - 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      busy      = (state_q != BK_IDLE);
      wr_en     = first_q;
      wr_mode   = (state_q == BK_RST_SLOW) ? MODE_SEL : MODE_DIRECT;
      wr_row    = row_q;
      wr_data   = hold_q;
      ev_skip   = (state_q == BK_FETCH) &&  dead_q;
      ev_direct = (state_q == BK_FETCH) && !dead_q &&  pending;
      ev_sel    = (state_q == BK_FETCH) && !dead_q && !pending;
   end

endmodule

// File: rtl/rrc_evcnt.sv
module rrc_evcnt #(
   parameter int NB    = 4,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NB-1:0]    ev,
   output logic [CNT_W-1:0] cnt
);

   logic [CNT_W-1:0] inc;

   always_comb begin
      inc = '0;
      for (int i = 0; i < NB; i++) inc = inc + CNT_W'(ev[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + inc;
   end

endmodule

// File: rtl/restore_ctl.sv
module restore_ctl
   import rrc_pkg::*;
#(
   parameter int NUM_BANKS  = 4,
   parameter int REG_ID_W   = 8,
   parameter int DATA_W     = 32,
   parameter int DIRECT_CYC = 1,
   parameter int SEL_CYC    = 3,
   parameter int CNT_W      = 16,
   localparam int BANK_W    = $clog2(NUM_BANKS),
   localparam int ROW_W     = REG_ID_W - BANK_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [REG_ID_W-1:0]           req_reg_id,
   input  logic                          req_dead,
   input  logic                          req_buf_hit,
   output logic                          req_ready,
   input  logic [NUM_BANKS-1:0]          bank_pending,
   output logic                          arr_rd_en,
   output logic [BANK_W-1:0]             arr_rd_bank,
   output logic [ROW_W-1:0]              arr_rd_row,
   input  logic [DATA_W-1:0]             arr_rd_data,
   output logic [NUM_BANKS-1:0]          rst_wr_en,
   output logic [NUM_BANKS-1:0]          rst_wr_mode,
   output logic [NUM_BANKS*ROW_W-1:0]    rst_wr_row,
   output logic [NUM_BANKS*DATA_W-1:0]   rst_wr_data,
   output logic [NUM_BANKS-1:0]          bank_busy,
   output logic [CNT_W-1:0]              cnt_skip,
   output logic [CNT_W-1:0]              cnt_direct,
   output logic [CNT_W-1:0]              cnt_sel
);

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("restore_ctl: NUM_BANKS must be a power of two of at least 2");
   end
   if (REG_ID_W <= BANK_W) begin : g_bad_id
      $error("restore_ctl: REG_ID_W must exceed the bank select width");
   end
   if (DIRECT_CYC < 1 || SEL_CYC <= DIRECT_CYC) begin : g_bad_cyc
      $error("restore_ctl: need 1 <= DIRECT_CYC < SEL_CYC");
   end

   logic [BANK_W-1:0]    bank_sel;
   logic [ROW_W-1:0]     row_sel;
   logic                 fire;
   logic [NUM_BANKS-1:0] ev_skip, ev_direct, ev_sel;

   assign bank_sel    = req_reg_id[BANK_W-1:0];
   assign row_sel     = req_reg_id[REG_ID_W-1:BANK_W];
   assign req_ready   = req_buf_hit | ~bank_busy[bank_sel];
   assign fire        = req_valid & req_ready & ~req_buf_hit;
   assign arr_rd_en   = fire;
   assign arr_rd_bank = bank_sel;
   assign arr_rd_row  = row_sel;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      rrc_bank #(
         .ROW_W      (ROW_W),
         .DATA_W     (DATA_W),
         .DIRECT_CYC (DIRECT_CYC),
         .SEL_CYC    (SEL_CYC)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (fire && (bank_sel == BANK_W'(b))),
         .start_dead (req_dead),
         .start_row  (row_sel),
         .pending    (bank_pending[b]),
         .rd_data    (arr_rd_data),
         .wr_en      (rst_wr_en[b]),
         .wr_mode    (rst_wr_mode[b]),
         .wr_row     (rst_wr_row[b*ROW_W +: ROW_W]),
         .wr_data    (rst_wr_data[b*DATA_W +: DATA_W]),
         .busy       (bank_busy[b]),
         .ev_skip    (ev_skip[b]),
         .ev_direct  (ev_direct[b]),
         .ev_sel     (ev_sel[b])
      );
   end

   rrc_evcnt #(.NB(NUM_BANKS), .CNT_W(CNT_W)) u_cnt_skip (
      .clk (clk), .rst_n (rst_n), .ev (ev_skip),   .cnt (cnt_skip));
   rrc_evcnt #(.NB(NUM_BANKS), .CNT_W(CNT_W)) u_cnt_direct (
      .clk (clk), .rst_n (rst_n), .ev (ev_direct), .cnt (cnt_direct));
   rrc_evcnt #(.NB(NUM_BANKS), .CNT_W(CNT_W)) u_cnt_sel (
      .clk (clk), .rst_n (rst_n), .ev (ev_sel),    .cnt (cnt_sel));

endmodule

// File: rtl/rrc_chk.sv
module rrc_chk #(
   parameter int NB     = 4,
   parameter int BANK_W = 2,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_buf_hit,
   input logic [BANK_W-1:0] req_bank,
   input logic              arr_rd_en,
   input logic [BANK_W-1:0] arr_rd_bank,
   input logic [NB-1:0]     rst_wr_en,
   input logic [NB-1:0]     bank_busy,
   input logic [CNT_W-1:0]  cnt_skip,
   input logic [CNT_W-1:0]  cnt_direct,
   input logic [CNT_W-1:0]  cnt_sel
);

   // R7: no array read is issued to a bank that is occupied
   a_r7_no_read_busy_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_buf_hit && bank_busy[req_bank]) |-> !arr_rd_en);

   // R2: an accepted read occupies its bank in the next cycle
   a_r2_read_occupies: assert property (@(posedge clk) disable iff (!rst_n)
      arr_rd_en |=> bank_busy[$past(arr_rd_bank)]);

   // R2: a restore write only comes from an occupied bank
   a_r2_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ((rst_wr_en & ~bank_busy) == '0));

   // R8: at most one restore write per cycle, since one read returns per cycle
   a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rst_wr_en));

   // R6: a buffer-served read never reaches the array
   a_r6_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_buf_hit) |-> !arr_rd_en);

   // R9: counters step by zero or one
   a_r9_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_skip == $past(cnt_skip)) || (cnt_skip == $past(cnt_skip) + 1'b1));
   a_r9_direct_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_direct == $past(cnt_direct)) || (cnt_direct == $past(cnt_direct) + 1'b1));
   a_r9_sel_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_sel == $past(cnt_sel)) || (cnt_sel == $past(cnt_sel) + 1'b1));

endmodule

bind restore_ctl rrc_chk #(
   .NB     (NUM_BANKS),
   .BANK_W (BANK_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_buf_hit (req_buf_hit),
   .req_bank    (bank_sel),
   .arr_rd_en   (arr_rd_en),
   .arr_rd_bank (arr_rd_bank),
   .rst_wr_en   (rst_wr_en),
   .bank_busy   (bank_busy),
   .cnt_skip    (cnt_skip),
   .cnt_direct  (cnt_direct),
   .cnt_sel     (cnt_sel)
);

// File: tb/restore_ctl_tb.sv
`timescale 1ns/1ps
module restore_ctl_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [7:0]   req_reg_id = '0;
   logic         req_dead = 1'b0;
   logic         req_buf_hit = 1'b0;
   logic         req_ready;
   logic [3:0]   pend = '0;
   logic         arr_rd_en;
   logic [1:0]   arr_rd_bank;
   logic [5:0]   arr_rd_row;
   logic [31:0]  arr_rd_data = 32'hDEAD_BEEF;
   logic [3:0]   rst_wr_en, rst_wr_mode, bank_busy;
   logic [23:0]  rst_wr_row;
   logic [127:0] rst_wr_data;
   logic [15:0]  cnt_skip, cnt_direct, cnt_sel;

   int n_chk = 0, n_fail = 0;
   int e_skip = 0, e_direct = 0, e_sel = 0;
   bit finished = 1'b0;
   logic [40:0] exp_q[$];

   always #4 clk = ~clk;

   restore_ctl u_dut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_reg_id (req_reg_id),
      .req_dead (req_dead), .req_buf_hit (req_buf_hit), .req_ready (req_ready),
      .bank_pending (pend), .arr_rd_en (arr_rd_en), .arr_rd_bank (arr_rd_bank),
      .arr_rd_row (arr_rd_row), .arr_rd_data (arr_rd_data), .rst_wr_en (rst_wr_en),
      .rst_wr_mode (rst_wr_mode), .rst_wr_row (rst_wr_row), .rst_wr_data (rst_wr_data),
      .bank_busy (bank_busy), .cnt_skip (cnt_skip), .cnt_direct (cnt_direct),
      .cnt_sel (cnt_sel));

   function automatic logic [31:0] pat(input logic [1:0] b, input logic [5:0] r);
      return {8'h5A, 2'b00, b, 4'h0, 2'b00, r, 2'b00, r ^ 6'h15};
   endfunction

   // array model: data one cycle after the strobe, junk otherwise
   always @(posedge clk) begin
      if (arr_rd_en) arr_rd_data <= pat(arr_rd_bank, arr_rd_row);
      else           arr_rd_data <= 32'hDEAD_BEEF;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: compare each restore write against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int b = 0; b < 4; b++) begin
            if (rst_wr_en[b]) begin
               if (exp_q.size() == 0) begin
                  chk("R3 unexpected restore write bank", 64'(b), 64'hFF);
               end else begin
                  logic [40:0] e;
                  e = exp_q.pop_front();
                  chk("R1 write bank", 64'(b), 64'(e[40:39]));
                  chk("R1 write row", 64'(rst_wr_row[b*6 +: 6]), 64'(e[38:33]));
                  chk("R2/R8 write data", 64'(rst_wr_data[b*32 +: 32]), 64'(e[32:1]));
                  chk("R4/R5 write mode", 64'(rst_wr_mode[b]), 64'(e[0]));
               end
            end
         end
      end
   end

   task automatic issue(input logic [7:0] id, input logic dead, input logic hit);
      req_reg_id = id; req_dead = dead; req_buf_hit = hit; req_valid = 1'b1;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      if (!hit) begin
         if (dead) e_skip++;
         else begin
            exp_q.push_back({id[1:0], id[7:2], pat(id[1:0], id[7:2]), ~pend[id[1:0]]});
            if (pend[id[1:0]]) e_direct++; else e_sel++;
         end
      end
      @(negedge clk);
      req_valid = 1'b0; req_dead = 1'b0; req_buf_hit = 1'b0;
   endtask

   task automatic wait_idle();
      while (bank_busy != 4'h0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic chk_counts(input string tag);
      chk({tag, " skip count"},   64'(cnt_skip),   64'(e_skip));
      chk({tag, " direct count"}, 64'(cnt_direct), 64'(e_direct));
      chk({tag, " sel count"},    64'(cnt_sel),    64'(e_sel));
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      wrap_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      #1;
      chk("R9 reset ready", 64'(req_ready), 64'd1);
      chk("R9 reset busy", 64'(bank_busy), 64'd0);
      chk("R9 reset write", 64'(rst_wr_en), 64'd0);
      chk_counts("R9 reset");
      @(negedge clk);

      // R5 + R1: idle bank, selective restore, 4 busy cycles
      pend = 4'b0000;
      issue(8'h25, 1'b0, 1'b0);
      chk("R5 busy c1", 64'(bank_busy[1]), 64'd1);
      @(negedge clk); chk("R5 busy c2", 64'(bank_busy[1]), 64'd1);
      @(negedge clk); chk("R5 busy c3", 64'(bank_busy[1]), 64'd1);
      @(negedge clk); chk("R5 busy c4", 64'(bank_busy[1]), 64'd1);
      @(negedge clk); chk("R5 released", 64'(bank_busy[1]), 64'd0);

      // R4: pending bank, direct restore, 2 busy cycles
      pend = 4'b0100;
      issue(8'h12, 1'b0, 1'b0);
      chk("R4 busy c1", 64'(bank_busy[2]), 64'd1);
      @(negedge clk); chk("R4 busy c2", 64'(bank_busy[2]), 64'd1);
      @(negedge clk); chk("R4 released", 64'(bank_busy[2]), 64'd0);
      pend = 4'b0000;

      // R3: last-use read, no write, one busy cycle
      issue(8'h33, 1'b1, 1'b0);
      chk("R3 busy c1", 64'(bank_busy[3]), 64'd1);
      @(negedge clk); chk("R3 released", 64'(bank_busy[3]), 64'd0);
      chk("R3 skip count", 64'(cnt_skip), 64'(e_skip));
      wait_idle();
      chk_counts("R9 after single reads");

      // R6: buffer hit has no effect on the array or counters
      req_reg_id = 8'h04; req_buf_hit = 1'b1; req_valid = 1'b1;
      #1;
      chk("R6 hit ready", 64'(req_ready), 64'd1);
      chk("R6 hit no array read", 64'(arr_rd_en), 64'd0);
      @(negedge clk);
      req_valid = 1'b0; req_buf_hit = 1'b0;
      chk("R6 hit no busy", 64'(bank_busy), 64'd0);
      @(negedge clk);
      chk("R6 hit no write", 64'(rst_wr_en), 64'd0);
      chk_counts("R6 after hit");

      // R7 + R8: refused read to busy bank, overlapping read to another bank
      issue(8'h40, 1'b0, 1'b0);
      req_reg_id = 8'h44; req_valid = 1'b1; req_dead = 1'b0; req_buf_hit = 1'b0;
      #1;
      chk("R7 busy bank refused", 64'(req_ready), 64'd0);
      chk("R7 no read to busy bank", 64'(arr_rd_en), 64'd0);
      req_reg_id = 8'h41;
      #1;
      chk("R7 other bank accepted", 64'(req_ready), 64'd1);
      issue(8'h41, 1'b0, 1'b0);
      wait_idle();

      // R3: value read three times, only last read marked last-use
      issue(8'h2A, 1'b0, 1'b0); wait_idle();
      issue(8'h2A, 1'b0, 1'b0); wait_idle();
      issue(8'h2A, 1'b1, 1'b0); wait_idle();
      chk_counts("R3 multi-read");

      // mixed back-to-back stream, fixed per-bank pending
      pend = 4'b0101;
      for (int k = 0; k < 24; k++) begin
         logic [7:0] id;
         id = 8'((k * 37 + 11) & 8'hFF);
         issue(id, (k % 3) == 2, (k % 5) == 4);
      end
      wait_idle();
      pend = 4'b0000;
      repeat (2) @(negedge clk);
      chk_counts("R9 final");
      chk("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
      wrap_up();
   end

endmodule